// File: doc/BRIEF.md
# Slave-Serial Configuration Loader

This block brings a target FPGA out of an unconfigured state on its own, with no processor time beyond a one-cycle start strobe. When started it first looks at the target's completion status. If the target is already configured, the block ends at once. Otherwise it resets the target through an active-high enable that pulls the target's program pin low. It then waits for the target to report that it is ready and streams a fixed-length image to it.

Image bytes come from a byte-wide memory read port at consecutive addresses above a base address. The port uses a request/valid handshake. Each byte goes out most significant bit first on a serial data line, beside a configuration clock made by a programmable divider. After the last bit the block waits for the target's completion input. Both the ready wait and the completion wait are bounded by a timeout, and a timeout ends the run with a sticky error.

Top module: `sscfg_loader`

## Requirements
- R1: If the synchronized completion input is high when start is accepted, the block finishes in the same cycle. `done_o` is high one cycle later and `busy_o` is low. `prog_oe_o` never rises, no memory request is made, and no configuration clock edge occurs.
- R2: `prog_oe_o` is an active-high enable that holds the target's program pin low while high. It is 0 after reset and is 0 whenever the block is idle.
- R3: An accepted start runs this reset pulse: `prog_oe_o` is high for exactly DLY_CYC cycles, then low for exactly DLY_CYC cycles, then high again. Polling of the ready input starts after that.
- R4: No memory request and no configuration clock edge happen before the synchronized ready input is seen high. The ready input is sampled once every DLY_CYC cycles.
- R5: The block reads exactly IMG_LEN bytes from addresses base, base+1, and so on up to base+IMG_LEN-1, where base is latched at start. A request stays high until valid is seen, and the byte count advances only on valid.
- R6: A byte is loaded into the shifter only after the previous byte has fully left it. Bytes go out in address order.
- R7: Bits go out MSB first. Data changes only when the configuration clock falls. Each high phase of the configuration clock lasts div+1 system cycles, where div is latched at start.
- R8: After the last bit, `done_o` stays low and `busy_o` stays high until the synchronized completion input goes high. The run then ends with `done_o` high and `prog_oe_o` low.
- R9: If the ready wait or the completion wait lasts TMO_CYC cycles, `err_o` is set and stays set. The block returns to idle with `prog_oe_o` low. `err_o` and `done_o` are never high together.
- R10: A start strobe received while `busy_o` is high is ignored. The running image transfer and the reset pulse go on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start strobe |
| base_addr_i | input | ADDR_W | Image base address, latched at start |
| div_i | input | DIV_W | Clock divider setting, latched at start |
| done_pin_i | input | 1 | Target completion status (asynchronous) |
| init_pin_i | input | 1 | Target ready status (asynchronous) |
| prog_oe_o | output | 1 | Enable that pulls the target program pin low when high |
| cclk_o | output | 1 | Configuration clock |
| sdata_o | output | 1 | Serial configuration data |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_valid_i | input | 1 | Read data valid |
| mem_data_i | input | 8 | Read data byte |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sticky success flag, cleared by an accepted start |
| err_o | output | 1 | Sticky timeout flag, cleared by an accepted start |

## Verification
The skip case of R1 is due one cycle after the start strobe, so the bench checks `done_o` at the very next falling edge. The reset pulse of R3 is measured by counting the falling-edge samples of each level of `prog_oe_o`; each level must last exactly DLY_CYC samples. The serial stream is checked at every rising configuration-clock edge as it happens, and each high phase is timed against div+1 cycles. Completion and timeout results pass through a two-flop synchronizer and then a state register, so the bench allows several cycles of settling before it reads them. For R8 it checks the still-busy state well before it raises the completion input.

// File: rtl/sscfg_pkg.sv
package sscfg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PHI1,
        ST_PLO,
        ST_POLL,
        ST_STREAM,
        ST_DRAIN,
        ST_WDONE
    } seq_st_e;
endpackage

// File: rtl/sscfg_sync.sv
module sscfg_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_i[i];
                stab_q <= meta_q;
            end
        end
        assign sync_o[i] = stab_q;
    end
endmodule

// File: rtl/sscfg_shifter.sv
module sscfg_shifter #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_i,
    input  logic [7:0]       byte_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             empty_o,
    output logic             cclk_o,
    output logic             sdata_o
);
    typedef struct packed {
        logic             act;
        logic             cclk;
        logic [7:0]       sreg;
        logic [2:0]       bitn;
        logic [DIV_W-1:0] tick;
    } sh_t;

    sh_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (ld_i) begin
            r_d.act  = 1'b1;
            r_d.sreg = byte_i;
            r_d.bitn = '0;
            r_d.cclk = 1'b0;
            r_d.tick = '0;
        end else if (r_q.act) begin
            if (r_q.tick == div_i) begin
                r_d.tick = '0;
                r_d.cclk = !r_q.cclk;
                if (r_q.cclk) begin
                    if (r_q.bitn == 3'd7) begin
                        r_d.act = 1'b0;
                    end else begin
                        r_d.bitn = r_q.bitn + 3'd1;
                        r_d.sreg = {r_q.sreg[6:0], 1'b0};
                    end
                end
            end else begin
                r_d.tick = r_q.tick + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign empty_o = !r_q.act;
    assign cclk_o  = r_q.cclk;
    assign sdata_o = r_q.sreg[7];

    AST_SDATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cclk && $past(r_q.cclk)) |-> $stable(r_q.sreg[7])) else $error("sdata moved while clock high"); // R7
    AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.act |-> !r_q.cclk) else $error("clock high while idle"); // R7
endmodule

// File: rtl/sscfg_loader.sv
module sscfg_loader
    import sscfg_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DIV_W   = 4,
    parameter int IMG_LEN = 169216,
    parameter int DLY_CYC = 64,
    parameter int TMO_CYC = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              done_pin_i,
    input  logic              init_pin_i,
    output logic              prog_oe_o,
    output logic              cclk_o,
    output logic              sdata_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_valid_i,
    input  logic [7:0]        mem_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    localparam int CNT_W = $clog2(IMG_LEN + 1);
    localparam int DLY_W = $clog2(DLY_CYC + 1);
    localparam int TMO_W = $clog2(TMO_CYC + 1);
    localparam logic [CNT_W-1:0] LEN_C    = CNT_W'(IMG_LEN);
    localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(DLY_CYC - 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYC - 1);

    typedef struct packed {
        seq_st_e           st;
        logic [DLY_W-1:0]  dly;
        logic [TMO_W-1:0]  tmo;
        logic [CNT_W-1:0]  fetched;
        logic [CNT_W-1:0]  sent;
        logic [ADDR_W-1:0] base;
        logic [DIV_W-1:0]  div;
        logic [7:0]        bbyte;
        logic              bvld;
        logic              req;
        logic              ld;
        logic              oe;
        logic              done;
        logic              err;
    } seq_t;

    seq_t r_q, r_d;
    logic [1:0] pins_s;
    logic done_s, init_s, sh_empty;

    sscfg_sync #(.W(2)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .async_i({done_pin_i, init_pin_i}),
        .sync_o(pins_s)
    );
    assign done_s = pins_s[1];
    assign init_s = pins_s[0];

    sscfg_shifter #(.DIV_W(DIV_W)) shift_i (
        .clk(clk), .rst_n(rst_n),
        .ld_i(r_q.ld), .byte_i(r_q.bbyte), .div_i(r_q.div),
        .empty_o(sh_empty), .cclk_o(cclk_o), .sdata_o(sdata_o)
    );

    always_comb begin
        r_d    = r_q;
        r_d.ld = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.err  = 1'b0;
                    r_d.done = 1'b0;
                    r_d.base = base_addr_i;
                    r_d.div  = div_i;
                    if (done_s) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st  = ST_PHI1;
                        r_d.oe  = 1'b1;
                        r_d.dly = '0;
                    end
                end
            end
            ST_PHI1: begin
                if (r_q.dly == DLY_LAST) begin
                    r_d.dly = '0;
                    r_d.oe  = 1'b0;
                    r_d.st  = ST_PLO;
                end else begin
                    r_d.dly = r_q.dly + 1'b1;
                end
            end
            ST_PLO: begin
                if (r_q.dly == DLY_LAST) begin
                    r_d.dly     = '0;
                    r_d.oe      = 1'b1;
                    r_d.tmo     = '0;
                    r_d.fetched = '0;
                    r_d.sent    = '0;
                    r_d.bvld    = 1'b0;
                    r_d.req     = 1'b0;
                    r_d.st      = ST_POLL;
                end else begin
                    r_d.dly = r_q.dly + 1'b1;
                end
            end
            ST_POLL: begin
                r_d.tmo = r_q.tmo + 1'b1;
                if (r_q.tmo == TMO_LAST) begin
                    r_d.err = 1'b1;
                    r_d.oe  = 1'b0;
                    r_d.st  = ST_IDLE;
                end else if (r_q.dly == DLY_LAST) begin
                    r_d.dly = '0;
                    if (init_s) r_d.st = ST_STREAM;
                end else begin
                    r_d.dly = r_q.dly + 1'b1;
                end
            end
            ST_STREAM: begin
                if (r_q.req && mem_valid_i) begin
                    r_d.req     = 1'b0;
                    r_d.bbyte   = mem_data_i;
                    r_d.bvld    = 1'b1;
                    r_d.fetched = r_q.fetched + 1'b1;
                end else if (!r_q.req && !r_q.bvld && r_q.fetched != LEN_C) begin
                    r_d.req = 1'b1;
                end
                if (r_q.bvld && sh_empty && !r_q.ld) begin
                    r_d.ld   = 1'b1;
                    r_d.bvld = 1'b0;
                    r_d.sent = r_q.sent + 1'b1;
                    if (r_q.sent + 1'b1 == LEN_C) r_d.st = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (sh_empty && !r_q.ld) begin
                    r_d.tmo = '0;
                    r_d.st  = ST_WDONE;
                end
            end
            ST_WDONE: begin
                r_d.tmo = r_q.tmo + 1'b1;
                if (done_s) begin
                    r_d.done = 1'b1;
                    r_d.oe   = 1'b0;
                    r_d.st   = ST_IDLE;
                end else if (r_q.tmo == TMO_LAST) begin
                    r_d.err = 1'b1;
                    r_d.oe  = 1'b0;
                    r_d.st  = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign prog_oe_o  = r_q.oe;
    assign mem_req_o  = r_q.req;
    assign mem_addr_o = r_q.base + ADDR_W'(r_q.fetched);
    assign busy_o     = (r_q.st != ST_IDLE);
    assign done_o     = r_q.done;
    assign err_o      = r_q.err;

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!prog_oe_o && !mem_req_o)) else $error("idle with enable or request"); // R2
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_valid_i) |=> mem_req_o) else $error("request dropped early"); // R5
    AST_SENT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.sent <= LEN_C) else $error("byte count overflow"); // R5
    AST_LOAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ld |-> sh_empty) else $error("load while shifting"); // R6
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o)) else $error("done and error together"); // R9
    AST_BUSY_START_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(r_q.base)) else $error("base changed while busy"); // R10
endmodule

// File: tb/sscfg_loader_tb.sv
module sscfg_loader_tb_top;
    localparam int ADDR_W = 16;
    localparam int DIV_W  = 4;
    localparam int LEN    = 6;
    localparam int DLY    = 8;
    localparam int TMO    = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [DIV_W-1:0]  div = '0;
    logic done_pin = 1'b0, init_pin = 1'b0;
    logic prog_oe, cclk, sdata, mem_req, mem_valid = 1'b0, busy, done_f, err_f;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_data = '0;

    int total = 0, fails = 0;

    always #2.5 clk = !clk;

    sscfg_loader #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .IMG_LEN(LEN),
                   .DLY_CYC(DLY), .TMO_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .base_addr_i(base_addr),
        .div_i(div), .done_pin_i(done_pin), .init_pin_i(init_pin),
        .prog_oe_o(prog_oe), .cclk_o(cclk), .sdata_o(sdata),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_valid_i(mem_valid),
        .mem_data_i(mem_data), .busy_o(busy), .done_o(done_f), .err_o(err_f)
    );

    function automatic logic [7:0] img_byte(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ (a[15:8] * 8'd3) ^ 8'h5A;
    endfunction

    // monitor state
    logic [ADDR_W-1:0] cur_base = '0;
    int cur_div = 0, lat_max = 0, lat_cnt = 0, fetch_idx = 0;
    int addr_bad = 0, req_seen = 0, cclk_rises = 0, rx_cnt = 0, byte_bad = 0;
    int hi_bad = 0, sd_bad = 0, oe_rises = 0, hi_len = 0, lo_len = 0;
    int oe_run = 0, ck_run = 0, bitn = 0;
    logic [7:0] rx_sh = '0;
    logic p_oe = 1'b0, p_ck = 1'b0, p_sd = 1'b0;

    task automatic clear_stats();
        fetch_idx = 0; addr_bad = 0; req_seen = 0; cclk_rises = 0; rx_cnt = 0;
        byte_bad = 0; hi_bad = 0; sd_bad = 0; oe_rises = 0; hi_len = 0; lo_len = 0;
        bitn = 0; lat_cnt = 0;
    endtask

    // memory model
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_valid = 1'b0;
        end else if (mem_valid) begin
            mem_valid = 1'b0;
        end else if (mem_req) begin
            if (lat_cnt == 0) begin
                if (mem_addr != cur_base + ADDR_W'(fetch_idx)) addr_bad++;
                fetch_idx++;
                mem_data  = img_byte(mem_addr);
                mem_valid = 1'b1;
                lat_cnt   = (lat_max == 0) ? 0 : int'($urandom % (lat_max + 1));
            end else begin
                lat_cnt--;
            end
        end
    end

    // port monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req) req_seen++;
            if (prog_oe != p_oe) begin
                if (prog_oe) oe_rises++;
                if (!prog_oe && oe_rises == 1) hi_len = oe_run;
                if (prog_oe && oe_rises == 2) lo_len = oe_run;
                oe_run = 1;
            end else oe_run++;
            if (cclk && !p_ck) begin
                cclk_rises++;
                rx_sh = {rx_sh[6:0], sdata};
                bitn++;
                if (bitn == 8) begin
                    if (rx_sh != img_byte(cur_base + ADDR_W'(rx_cnt))) byte_bad++;
                    rx_cnt++;
                    bitn = 0;
                end
                ck_run = 1;
            end else if (cclk) ck_run++;
            if (!cclk && p_ck && ck_run != cur_div + 1) hi_bad++;
            if (cclk && p_ck && sdata != p_sd) sd_bad++;
        end
        p_oe = prog_oe; p_ck = cclk; p_sd = sdata;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic full_run(input logic [ADDR_W-1:0] b, input int d, input int lat,
                            input int init_dly, input bit restart);
        done_pin = 1'b0; init_pin = 1'b0;
        cyc(4);
        clear_stats();
        cur_base = b; cur_div = d; lat_max = lat;
        base_addr = b; div = DIV_W'(d);
        pulse_start();
        chk("R1 busy after start", int'(busy), 1);
        cyc(init_dly);
        chk("R4 no request before ready", req_seen, 0);
        chk("R4 no clock before ready", cclk_rises, 0);
        init_pin = 1'b1;
        if (restart) begin
            for (int i = 0; i < 20000 && rx_cnt < 2; i++) @(negedge clk);
            base_addr = b + 16'd100;
            pulse_start();  // R10: must be ignored
        end
        for (int i = 0; i < 20000 && rx_cnt < LEN; i++) @(negedge clk);
        cyc(12);
        chk("R8 busy while awaiting done", int'(busy), 1);
        chk("R8 done low while awaiting", int'(done_f), 0);
        done_pin = 1'b1;
        cyc(6);
        chk("R8 done flag", int'(done_f), 1);
        chk("R8 idle after done", int'(busy), 0);
        chk("R2 enable released", int'(prog_oe), 0);
        chk("R9 no error", int'(err_f), 0);
        chk("R5 bytes received", rx_cnt, LEN);
        chk("R5 address sequence", addr_bad, 0);
        chk("R5 bytes fetched", fetch_idx, LEN);
        chk("R6 R7 byte content MSB first", byte_bad, 0);
        chk("R7 high phase length", hi_bad, 0);
        chk("R7 data stable while high", sd_bad, 0);
        chk("R3 R10 enable rises", oe_rises, 2);
        chk("R3 first high length", hi_len, DLY);
        chk("R3 low length", lo_len, DLY);
    endtask

    initial begin
        #(5.0 * 150000);
        total++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int seed_v;
        seed_v = int'($urandom(32'd77));
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset busy", int'(busy), 0);
        chk("R2 reset done", int'(done_f), 0);
        chk("R2 reset err", int'(err_f), 0);
        chk("R2 reset enable", int'(prog_oe), 0);
        chk("R2 reset clock", int'(cclk), 0);
        chk("R2 reset request", int'(mem_req), 0);

        // R1: already configured
        done_pin = 1'b1;
        cyc(4);
        clear_stats();
        pulse_start();
        chk("R1 done next cycle", int'(done_f), 1);
        chk("R1 not busy", int'(busy), 0);
        cyc(6);
        chk("R1 enable untouched", oe_rises, 0);
        chk("R1 no request", req_seen, 0);
        chk("R1 no clock", cclk_rises, 0);

        // directed: fastest clock, slow memory, restart attempt
        full_run(16'h12F0, 0, 3, 60, 1'b1);

        // R9: ready never arrives
        done_pin = 1'b0; init_pin = 1'b0;
        cyc(4);
        clear_stats();
        pulse_start();
        chk("R9 done cleared by start", int'(done_f), 0);
        cyc(2 * DLY + TMO + 20);
        chk("R9 init timeout error", int'(err_f), 1);
        chk("R9 idle after init timeout", int'(busy), 0);
        chk("R9 enable released", int'(prog_oe), 0);
        chk("R4 no request without ready", req_seen, 0);

        // R9: completion never arrives
        clear_stats();
        cur_base = 16'h0400; cur_div = 1; lat_max = 1;
        base_addr = 16'h0400; div = 4'd1;
        pulse_start();
        chk("R9 error cleared by start", int'(err_f), 0);
        cyc(30);
        init_pin = 1'b1;
        for (int i = 0; i < 20000 && rx_cnt < LEN; i++) @(negedge clk);
        cyc(TMO + 30);
        chk("R9 done timeout error", int'(err_f), 1);
        chk("R9 no done on timeout", int'(done_f), 0);
        chk("R9 idle after done timeout", int'(busy), 0);

        // constrained random runs
        for (int k = 0; k < 4; k++) begin
            full_run(ADDR_W'($urandom), int'($urandom % 4), int'($urandom % 4),
                     30 + int'($urandom % 60), 1'b0);
        end
        summary();
    end
endmodule